// File: doc/BRIEF.md
# Flash Command Status Tracker

This block holds the status word and the handshake logic that sit between a flash programming engine and the bus that issues commands to it. It tracks whether a command is running, and whether the write data, address and command registers are still held by the engine. It records completion, the first error code reported, and any ECC corrections or detections seen while signature commands run. It also records when the array has gone to sleep, and it raises an interrupt through a mask.

A command request is accepted when nothing is running. While a write is running, a second write request is accepted once the engine reports that it has consumed the write data and before it reports completion. If that second write falls in the same flash row as the one in progress, it is flagged as a burst write. Software clears the sticky status bits by writing ones to them. An event from the engine that sets a bit takes priority over a software clear of that bit in the same cycle.

Top module: `flash_stat_tracker`

## Requirements
- R1: After reset every status bit (`stat_o[8:0]`) is 0 and `irq_o` is 0.
- R2: `cmd_accept_o` is high for a request when busy (bit 0) is low, and busy is 1 from the cycle after acceptance until the cycle after `eng_done_i`. A request made while busy is ignored (no accept) unless it is a write inside the burst window (R5). Acceptance has priority over `eng_done_i` in the same cycle.
- R3: An accepted write sets write-closed (bit 1). The flag drops after `eng_consumed_i` or `eng_done_i`. `reg_accept_o` equals `reg_wr_i` while bit 1 is low and is 0 while it is high.
- R4: `eng_consumed_i` sets write-almost-complete (bit 3).
- R5: The burst window opens after `eng_consumed_i` while busy. It closes on `eng_done_i` or on any accepted command. A write request inside the window is accepted. `burst_wr_o` is high with that accept only when `cmd_addr_i[ADDR_W-1:ROW_LSB]` equals the row of the last accepted write.
- R6: Command-complete (bit 2) sets after `eng_done_i` or `por_done_i`. It clears after any accepted command, and that clear wins over a set in the same cycle.
- R7: The failure field [5:4] (00 complete, 01 ignored, 10 verify error, 11 aborted) loads a nonzero `eng_result_i` at `eng_done_i` only while the field is 00. Later errors are ignored until the field is cleared.
- R8: The ECC field [8:7] accumulates: `eng_ecc2_i` (uncorrected double-bit) sets bit 7, so the field reads 01. `eng_ecc1_i` (corrected single-bit) sets bit 8, so the field reads 10. Both together read 11.
- R9: Sleeping (bit 6) sets on `eng_sleep_i`. It clears on an accepted command with `cmd_idle_i` high or on `eng_wake_i`, and the clear wins over a set in the same cycle.
- R10: With `clr_wr_i` high, a 1 in `clr_mask_i` clears bits 8, 7, 3 and 2 individually. Either mask bit 5 or mask bit 4 clears the whole failure field. Bits 6, 1 and 0 are unaffected. A hardware set in the same cycle wins over the clear.
- R11: `ien_wr_i` loads `ien_wdata_i` into the enable mask. `irq_o` is high when any of status bits 8, 7, 5, 4, 3 or 2 is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_wr_i | input | 1 | Write-one-to-clear strobe for the status word |
| clr_mask_i | input | 9 | Bits to clear, aligned with the status word |
| ien_wr_i | input | 1 | Interrupt-enable write strobe |
| ien_wdata_i | input | 9 | Interrupt-enable value |
| reg_wr_i | input | 1 | Bus write to the data, address or command register |
| reg_accept_o | output | 1 | Register write allowed (write registers not closed) |
| cmd_req_i | input | 1 | Command request strobe |
| cmd_write_i | input | 1 | Requested command is a write |
| cmd_idle_i | input | 1 | Requested command is idle (wake) |
| cmd_addr_i | input | ADDR_W | Target byte address of the request |
| cmd_accept_o | output | 1 | Request accepted this cycle |
| burst_wr_o | output | 1 | Accepted request is a same-row burst write |
| eng_consumed_i | input | 1 | Engine has taken the write data |
| eng_done_i | input | 1 | Engine finished the command |
| eng_result_i | input | 2 | Result code given with eng_done_i |
| eng_ecc1_i | input | 1 | Single-bit ECC correction during signature command |
| eng_ecc2_i | input | 1 | Double-bit ECC detection during signature command |
| eng_sleep_i | input | 1 | Array entered low-power mode |
| eng_wake_i | input | 1 | Array woken for a data transaction |
| por_done_i | input | 1 | Power-up integrity sequence finished |
| stat_o | output | 9 | Status word |
| irq_o | output | 1 | Interrupt request |

## Verification
A stuck busy or closed flag is visible on `cmd_accept_o` and `reg_accept_o` in the same cycle as the next request. A stale row or window flag shows up as a wrong `burst_wr_o` on the first request after `eng_consumed_i`. A failure field that overwrites instead of holding the first error differs on `stat_o[5:4]` one cycle after the second `eng_done_i`. A wrong set-versus-clear priority shows on the sticky bits and on `irq_o` one cycle after the colliding strobes.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int STAT_W    = 9;
  localparam int ECC_N     = 2;
  localparam int B_BUSY    = 0;
  localparam int B_CLOSED  = 1;
  localparam int B_COMP    = 2;
  localparam int B_WRAL    = 3;
  localparam int B_FAIL_LO = 4;
  localparam int B_FAIL_HI = 5;
  localparam int B_SLEEP   = 6;
  localparam int B_ECC_LO  = 7;
  localparam int B_ECC_HI  = 8;
  localparam logic [STAT_W-1:0] STICKY_MASK = 9'h1BC;

  typedef enum logic [1:0] {
    FAIL_NONE    = 2'b00,
    FAIL_IGNORED = 2'b01,
    FAIL_VERIFY  = 2'b10,
    FAIL_ABORT   = 2'b11
  } fail_code_e;
endpackage

// File: rtl/fst_cmd_ctrl.sv
module fst_cmd_ctrl #(
  parameter int ADDR_W  = 17,
  parameter int ROW_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_req_i,
  input  logic              cmd_write_i,
  input  logic              cmd_idle_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              eng_consumed_i,
  input  logic              eng_done_i,
  input  logic              reg_wr_i,
  output logic              busy_o,
  output logic              closed_o,
  output logic              cmd_accept_o,
  output logic              idle_accept_o,
  output logic              burst_wr_o,
  output logic              reg_accept_o
);
  localparam int ROW_W = ADDR_W - ROW_LSB;

  logic             busy_q, busy_d;
  logic             closed_q, closed_d;
  logic             win_q, win_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             row_en;
  logic             accept;
  logic             same_row;
  logic             addr_lo_unused;

  assign addr_lo_unused = ^cmd_addr_i[ROW_LSB-1:0];

  // request decode
  always_comb begin
    same_row = (cmd_addr_i[ADDR_W-1:ROW_LSB] == row_q);
    accept   = cmd_req_i && (!busy_q || (win_q && cmd_write_i));
  end

  // next state
  always_comb begin
    busy_d = busy_q;
    if (accept)          busy_d = 1'b1;
    else if (eng_done_i) busy_d = 1'b0;

    closed_d = closed_q;
    if (accept && cmd_write_i)            closed_d = 1'b1;
    else if (eng_consumed_i || eng_done_i) closed_d = 1'b0;

    win_d = win_q;
    if (accept || eng_done_i)         win_d = 1'b0;
    else if (eng_consumed_i && busy_q) win_d = 1'b1;

    row_en = accept && cmd_write_i;
    row_d  = cmd_addr_i[ADDR_W-1:ROW_LSB];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      closed_q <= 1'b0;
      win_q    <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      closed_q <= closed_d;
      win_q    <= win_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (row_en) begin
      row_q <= row_d;
    end
  end

  assign busy_o        = busy_q;
  assign closed_o      = closed_q;
  assign cmd_accept_o  = accept;
  assign idle_accept_o = accept && cmd_idle_i;
  assign burst_wr_o    = accept && win_q && cmd_write_i && same_row;
  assign reg_accept_o  = reg_wr_i && !closed_q;

  AST_CLOSED_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    closed_q |-> busy_q); // R3
  AST_BURST_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    burst_wr_o |-> (busy_q && !closed_q)); // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !eng_done_i) |=> busy_q); // R2
endmodule

// File: rtl/fst_status.sv
module fst_status
  import flash_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_accept_i,
  input  logic             idle_accept_i,
  input  logic             eng_done_i,
  input  logic [1:0]       eng_result_i,
  input  logic             eng_consumed_i,
  input  logic             por_done_i,
  input  logic             eng_ecc1_i,
  input  logic             eng_ecc2_i,
  input  logic             eng_sleep_i,
  input  logic             eng_wake_i,
  input  logic [ECC_N-1:0] clr_ecc_i,
  input  logic             clr_fail_i,
  input  logic             clr_wral_i,
  input  logic             clr_comp_i,
  output logic [ECC_N-1:0] ecc_o,
  output logic             sleep_o,
  output logic [1:0]       fail_o,
  output logic             wral_o,
  output logic             comp_o
);
  logic [ECC_N-1:0] ecc_set;
  logic [ECC_N-1:0] ecc_q;
  logic [1:0]       fail_q, fail_d;
  logic             fail_load;
  logic             sleep_q, sleep_d;
  logic             wral_q, wral_d;
  logic             comp_q, comp_d;

  // index 0 -> double-bit (status bit 7), index 1 -> single-bit (status bit 8)
  assign ecc_set = {eng_ecc1_i, eng_ecc2_i};

  for (genvar i = 0; i < ECC_N; i++) begin : g_ecc
    logic bit_d;
    always_comb begin
      bit_d = ecc_q[i];
      if (ecc_set[i])        bit_d = 1'b1;
      else if (clr_ecc_i[i]) bit_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ecc_q[i] <= 1'b0;
      else        ecc_q[i] <= bit_d;
    end
    AST_ECC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_set[i] |=> ecc_q[i]); // R8
  end

  always_comb begin
    fail_load = eng_done_i && (eng_result_i != FAIL_NONE) &&
                ((fail_q == FAIL_NONE) || clr_fail_i);
    fail_d = fail_q;
    if (fail_load)       fail_d = eng_result_i;
    else if (clr_fail_i) fail_d = FAIL_NONE;

    sleep_d = sleep_q;
    if (idle_accept_i || eng_wake_i) sleep_d = 1'b0;
    else if (eng_sleep_i)            sleep_d = 1'b1;

    wral_d = wral_q;
    if (eng_consumed_i)  wral_d = 1'b1;
    else if (clr_wral_i) wral_d = 1'b0;

    comp_d = comp_q;
    if (cmd_accept_i)                  comp_d = 1'b0;
    else if (eng_done_i || por_done_i) comp_d = 1'b1;
    else if (clr_comp_i)               comp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= FAIL_NONE;
      sleep_q <= 1'b0;
      wral_q  <= 1'b0;
      comp_q  <= 1'b0;
    end else begin
      fail_q  <= fail_d;
      sleep_q <= sleep_d;
      wral_q  <= wral_d;
      comp_q  <= comp_d;
    end
  end

  assign ecc_o   = ecc_q;
  assign fail_o  = fail_q;
  assign sleep_o = sleep_q;
  assign wral_o  = wral_q;
  assign comp_o  = comp_q;

  AST_FAIL_KEEPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((fail_q != FAIL_NONE) && !clr_fail_i) |=> $stable(fail_q)); // R7
  AST_COMP_CLEARED_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept_i |=> !comp_q); // R6
  AST_WRAL_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_consumed_i |=> wral_q); // R4
endmodule

// File: rtl/fst_irq.sv
module fst_irq
  import flash_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ien_wr_i,
  input  logic [STAT_W-1:0] ien_wdata_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              irq_o
);
  logic [STAT_W-1:0] ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ien_q <= '0;
    else if (ien_wr_i) ien_q <= ien_wdata_i;
  end

  assign irq_o = |(stat_i & ien_q & STICKY_MASK);

  AST_IRQ_NEEDS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((stat_i & STICKY_MASK) != '0)); // R11
endmodule

// File: rtl/flash_stat_tracker.sv
module flash_stat_tracker
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int ROW_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_wr_i,
  input  logic [8:0]        clr_mask_i,
  input  logic              ien_wr_i,
  input  logic [8:0]        ien_wdata_i,
  input  logic              reg_wr_i,
  output logic              reg_accept_o,
  input  logic              cmd_req_i,
  input  logic              cmd_write_i,
  input  logic              cmd_idle_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              cmd_accept_o,
  output logic              burst_wr_o,
  input  logic              eng_consumed_i,
  input  logic              eng_done_i,
  input  logic [1:0]        eng_result_i,
  input  logic              eng_ecc1_i,
  input  logic              eng_ecc2_i,
  input  logic              eng_sleep_i,
  input  logic              eng_wake_i,
  input  logic              por_done_i,
  output logic [8:0]        stat_o,
  output logic              irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             busy, closed, idle_accept;
  logic [ECC_N-1:0] ecc, clr_ecc;
  logic [1:0]       fail;
  logic             sleep, wral, comp;
  logic             clr_fail, clr_wral, clr_comp;
  logic             clr_ro_unused;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // clear decode: read-only positions take no effect
  assign clr_ecc       = clr_wr_i ? clr_mask_i[B_ECC_HI:B_ECC_LO] : '0;
  assign clr_fail      = clr_wr_i && (clr_mask_i[B_FAIL_HI] || clr_mask_i[B_FAIL_LO]);
  assign clr_wral      = clr_wr_i && clr_mask_i[B_WRAL];
  assign clr_comp      = clr_wr_i && clr_mask_i[B_COMP];
  assign clr_ro_unused = ^{clr_mask_i[B_SLEEP], clr_mask_i[B_CLOSED], clr_mask_i[B_BUSY]};

  fst_cmd_ctrl #(.ADDR_W(ADDR_W), .ROW_LSB(ROW_LSB)) u_cmd (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .cmd_req_i      (cmd_req_i),
    .cmd_write_i    (cmd_write_i),
    .cmd_idle_i     (cmd_idle_i),
    .cmd_addr_i     (cmd_addr_i),
    .eng_consumed_i (eng_consumed_i),
    .eng_done_i     (eng_done_i),
    .reg_wr_i       (reg_wr_i),
    .busy_o         (busy),
    .closed_o       (closed),
    .cmd_accept_o   (cmd_accept_o),
    .idle_accept_o  (idle_accept),
    .burst_wr_o     (burst_wr_o),
    .reg_accept_o   (reg_accept_o)
  );

  fst_status u_stat (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .cmd_accept_i   (cmd_accept_o),
    .idle_accept_i  (idle_accept),
    .eng_done_i     (eng_done_i),
    .eng_result_i   (eng_result_i),
    .eng_consumed_i (eng_consumed_i),
    .por_done_i     (por_done_i),
    .eng_ecc1_i     (eng_ecc1_i),
    .eng_ecc2_i     (eng_ecc2_i),
    .eng_sleep_i    (eng_sleep_i),
    .eng_wake_i     (eng_wake_i),
    .clr_ecc_i      (clr_ecc),
    .clr_fail_i     (clr_fail),
    .clr_wral_i     (clr_wral),
    .clr_comp_i     (clr_comp),
    .ecc_o          (ecc),
    .sleep_o        (sleep),
    .fail_o         (fail),
    .wral_o         (wral),
    .comp_o         (comp)
  );

  assign stat_o = {ecc, sleep, fail, wral, comp, closed, busy};

  fst_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .ien_wr_i    (ien_wr_i),
    .ien_wdata_i (ien_wdata_i),
    .stat_i      (stat_o),
    .irq_o       (irq_o)
  );

  AST_RO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (clr_wr_i && !cmd_req_i && !eng_done_i && !eng_consumed_i) |=> $stable(stat_o[B_CLOSED:B_BUSY])); // R10
endmodule

// File: tb/flash_stat_tracker_tb_top.sv
`timescale 1ns/100ps
module flash_stat_tracker_tb_top;
  localparam int ADDR_W  = 17;
  localparam int ROW_LSB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_wr, ien_wr, reg_wr, cmd_req, cmd_write, cmd_idle;
  logic [8:0] clr_mask, ien_wdata;
  logic [ADDR_W-1:0] cmd_addr;
  logic eng_consumed, eng_done, eng_ecc1, eng_ecc2, eng_sleep, eng_wake, por_done;
  logic [1:0] eng_result;
  logic reg_accept, cmd_accept, burst_wr, irq;
  logic [8:0] stat;

  always #2.5 clk = ~clk;

  flash_stat_tracker #(.ADDR_W(ADDR_W), .ROW_LSB(ROW_LSB)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .clr_wr_i(clr_wr), .clr_mask_i(clr_mask),
    .ien_wr_i(ien_wr), .ien_wdata_i(ien_wdata),
    .reg_wr_i(reg_wr), .reg_accept_o(reg_accept),
    .cmd_req_i(cmd_req), .cmd_write_i(cmd_write), .cmd_idle_i(cmd_idle),
    .cmd_addr_i(cmd_addr), .cmd_accept_o(cmd_accept), .burst_wr_o(burst_wr),
    .eng_consumed_i(eng_consumed), .eng_done_i(eng_done), .eng_result_i(eng_result),
    .eng_ecc1_i(eng_ecc1), .eng_ecc2_i(eng_ecc2), .eng_sleep_i(eng_sleep),
    .eng_wake_i(eng_wake), .por_done_i(por_done),
    .stat_o(stat), .irq_o(irq)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // behavioural reference state
  bit m_busy, m_closed, m_win, m_sleep, m_wral, m_comp, m_single, m_double;
  int m_fail, m_row, m_ien;
  int acc_cnt, burst_cnt;
  int rows_seen[$];

  function automatic bit exp_accept();
    if (!cmd_req) return 0;
    if (!m_busy) return 1;
    return m_win && cmd_write;
  endfunction

  function automatic bit exp_burst();
    return exp_accept() && m_win && cmd_write && (int'(cmd_addr) / 256 == m_row);
  endfunction

  function automatic int exp_stat();
    return (int'(m_single) << 8) | (int'(m_double) << 7) | (int'(m_sleep) << 6) |
           (m_fail << 4) | (int'(m_wral) << 3) | (int'(m_comp) << 2) |
           (int'(m_closed) << 1) | int'(m_busy);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_closed = 0; m_win = 0; m_sleep = 0; m_wral = 0; m_comp = 0;
      m_single = 0; m_double = 0; m_fail = 0; m_row = 0; m_ien = 0;
    end else begin
      bit a, clrf;
      a = exp_accept();
      if (a) acc_cnt++;
      if (exp_burst()) burst_cnt++;
      clrf = clr_wr && (clr_mask[5] || clr_mask[4]);
      if (eng_done && eng_result != 0 && (m_fail == 0 || clrf)) m_fail = int'(eng_result);
      else if (clrf) m_fail = 0;
      if (eng_ecc1) m_single = 1; else if (clr_wr && clr_mask[8]) m_single = 0;
      if (eng_ecc2) m_double = 1; else if (clr_wr && clr_mask[7]) m_double = 0;
      if ((a && cmd_idle) || eng_wake) m_sleep = 0; else if (eng_sleep) m_sleep = 1;
      if (eng_consumed) m_wral = 1; else if (clr_wr && clr_mask[3]) m_wral = 0;
      if (a) m_comp = 0; else if (eng_done || por_done) m_comp = 1;
      else if (clr_wr && clr_mask[2]) m_comp = 0;
      if (a) m_win = 0; else if (eng_done) m_win = 0; else if (eng_consumed && m_busy) m_win = 1;
      if (a && cmd_write) m_closed = 1; else if (eng_consumed || eng_done) m_closed = 0;
      if (a && cmd_write) begin m_row = int'(cmd_addr) / 256; rows_seen.push_back(m_row); end
      if (a) m_busy = 1; else if (eng_done) m_busy = 0;
      if (ien_wr) m_ien = int'(ien_wdata);
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 status at reset", int'(stat), 0);
      chk("R1 irq at reset", int'(irq), 0);
    end else begin
      int s;
      s = exp_stat();
      chk("R2 busy", int'(stat[0]), s & 1);
      chk("R3 closed", int'(stat[1]), (s >> 1) & 1);
      chk("R6 R10 complete", int'(stat[2]), (s >> 2) & 1);
      chk("R4 R10 almost complete", int'(stat[3]), (s >> 3) & 1);
      chk("R7 R10 failure field", int'(stat[5:4]), (s >> 4) & 3);
      chk("R9 sleeping", int'(stat[6]), (s >> 6) & 1);
      chk("R8 R10 ecc field", int'(stat[8:7]), (s >> 7) & 3);
      chk("R11 irq", int'(irq), int'((s & m_ien & 'h1BC) != 0));
      chk("R2 accept", int'(cmd_accept), int'(exp_accept()));
      chk("R5 burst", int'(burst_wr), int'(exp_burst()));
      chk("R3 register gate", int'(reg_accept), int'(reg_wr && !m_closed));
    end
  end

  task automatic idle_inputs();
    clr_wr = 0; clr_mask = '0; ien_wr = 0; ien_wdata = '0; reg_wr = 0;
    cmd_req = 0; cmd_write = 0; cmd_idle = 0; cmd_addr = '0;
    eng_consumed = 0; eng_done = 0; eng_result = 0; eng_ecc1 = 0; eng_ecc2 = 0;
    eng_sleep = 0; eng_wake = 0; por_done = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic req(input bit wr, input bit idl, input int addr);
    cmd_req = 1; cmd_write = wr; cmd_idle = idl; cmd_addr = ADDR_W'(addr);
    tick();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cycles);
        finish_run();
      end
    end
  end

  initial begin
    idle_inputs();
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) tick();
    // R6: power-up sequence end sets complete; R11 enable all
    por_done = 1; tick();
    ien_wr = 1; ien_wdata = 9'h1FF; tick();
    clr_wr = 1; clr_mask = 9'h004; tick();          // R10 clear complete
    // R2 R3: write accepted, registers closed, second request ignored
    req(1, 0, 'h0100);
    reg_wr = 1; tick();
    req(0, 0, 'h0200);
    // R4 R5: consumed opens the window, same-row write is a burst
    eng_consumed = 1; tick();
    reg_wr = 1; tick();
    req(1, 0, 'h01F0);
    eng_consumed = 1; tick();
    eng_done = 1; tick();
    // R5: other-row write inside the window is accepted, not a burst
    req(1, 0, 'h0300);
    eng_consumed = 1; tick();
    req(1, 0, 'h0500);
    eng_done = 1; tick();
    eng_done = 1; tick();
    // R7: first error held
    req(0, 0, 'h0000); eng_done = 1; eng_result = 2; tick();
    req(0, 0, 'h0000); eng_done = 1; eng_result = 1; tick();
    clr_wr = 1; clr_mask = 9'h010; tick();          // R10 clear by one mask bit
    req(0, 0, 'h0000); tick();
    eng_done = 1; eng_result = 3; clr_wr = 1; clr_mask = 9'h020; tick();  // set wins
    clr_wr = 1; clr_mask = 9'h1FF; tick();          // R10 read-only bits stay
    // R8 ECC accumulation and set-over-clear
    eng_ecc2 = 1; tick();
    eng_ecc1 = 1; tick();
    eng_ecc2 = 1; clr_wr = 1; clr_mask = 9'h180; tick();
    clr_wr = 1; clr_mask = 9'h100; tick();
    // R9 sleep and wake paths
    eng_sleep = 1; tick();
    req(0, 1, 0);
    eng_done = 1; tick();
    eng_sleep = 1; tick();
    eng_wake = 1; eng_sleep = 1; tick();
    // R11 masking
    ien_wr = 1; ien_wdata = 9'h008; tick();
    eng_consumed = 1; tick();
    clr_wr = 1; clr_mask = 9'h008; tick();
    ien_wr = 1; ien_wdata = 9'h1FF; tick();
    // mixed traffic over a few rows
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cmd_req = (r < 20); cmd_write = (r % 3 != 0); cmd_idle = (r % 7 == 0);
      cmd_addr = ADDR_W'($urandom_range(0, 'h3FF));
      reg_wr = ($urandom_range(0, 3) == 0);
      eng_consumed = ($urandom_range(0, 9) == 0);
      eng_done = ($urandom_range(0, 11) == 0);
      eng_result = 2'($urandom_range(0, 3));
      eng_ecc1 = ($urandom_range(0, 30) == 0);
      eng_ecc2 = ($urandom_range(0, 30) == 0);
      eng_sleep = ($urandom_range(0, 20) == 0);
      eng_wake = ($urandom_range(0, 25) == 0);
      clr_wr = ($urandom_range(0, 8) == 0);
      clr_mask = 9'($urandom_range(0, 511));
      ien_wr = ($urandom_range(0, 60) == 0);
      ien_wdata = 9'($urandom_range(0, 511));
      @(posedge clk); #1;
    end
    idle_inputs();
    repeat (3) tick();
    chk("R5 bursts exercised", int'(burst_cnt > 1), 1);
    chk("R2 accepts exercised", int'(acc_cnt > 10), 1);
    finish_run();
  end
endmodule